// File: doc/BRIEF.md
# DRAM Current-Test Command Loop Sequencer

This block produces the repeating command stream that a memory tester replays while it measures the current a DDR3-style device draws during back-to-back activate, read and precharge operations on one bank at a time. Each row-cycle period opens the selected bank, reads from it, and closes it again. The three command cycles come from programmable timing counts. Every other cycle carries a short repeating filler pattern of deselect and no-op slots. When the next command is due, the filler pattern is cut off.

Two row-cycle periods form one sub-loop on one bank. The first period's read uses an all-zero data pattern and the second uses the alternate pattern. The sub-loop then moves through every bank address in ascending order, and one full pass ends with a single-cycle done pulse. A start request latches the three timing counts. The block checks that the counts are in a legal order before it begins, and it raises an error flag and stays idle if they are not.

Top module: `cmd_loop_seq`

## Requirements
- R1: Command codes are 0 idle, 1 activate, 2 read, 3 precharge, 4 deselect, 5 no-op. While running, cycle 0 of every row-cycle period carries an activate.
- R2: Within a period, the read falls on cycle nRCD and the precharge on cycle nRAS. The period lasts nRC cycles, so the next activate comes nRC cycles after the previous one.
- R3: Every non-command cycle is a filler slot. Its phase is (cycles since the most recent command − 1) mod 4. Phases 0 and 1 give deselect (4) and phases 2 and 3 give no-op (5). The pattern restarts after every command and is cut off by the next one.
- R4: A sub-loop is two periods (2 × nRC cycles) on one bank address. Bank addresses step 0, 1, … 7, so a full pass takes 16 × nRC cycles and the address only changes on an activate cycle.
- R5: dataPat is 0x00 on the read of the first period of a sub-loop, 0x33 on the read of the second period, and 0x00 on every non-read cycle.
- R6: dmLevel is 0 at all times.
- R7: With the block idle and a legal configuration, start sampled high at a clock edge makes the next cycle an activate on bank 0. bankAddr reads 0 while idle.
- R8: loopDone is high for exactly the one cycle that follows the last cycle of bank 7's sub-loop. If start is high at that edge and the inputs are legal, that same cycle is the activate of a fresh pass on bank 0. Otherwise the block returns to idle (command 0).
- R9: The timing counts are captured when a pass begins. Changing the count inputs during a pass does not alter the sequence.
- R10: A start with an illegal configuration (anything other than 0 < nRCD < nRAS < nRC) sets cfgErr and leaves the block idle. A later start with a legal configuration clears cfgErr and begins a pass.
- R11: Reset forces command 0, bank 0, loopDone 0 and cfgErr 0, including when a pass is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (level, sampled while idle and at pass end) |
| rcdCycles | input | CNT_W | Activate-to-read distance nRCD |
| rasCycles | input | CNT_W | Activate-to-precharge distance nRAS |
| rcCycles | input | CNT_W | Row-cycle period nRC |
| cmdCode | output | 3 | Command issued in this cycle |
| bankAddr | output | BANK_W | Bank address of the current sub-loop |
| dataPat | output | 8 | Data pattern attached to a read |
| dmLevel | output | 1 | Data-mask level, held low |
| loopDone | output | 1 | One-cycle pulse after a full pass |
| cfgErr | output | 1 | Last start request had illegal timing counts |

## Verification
The hardest case to reach from the ports is the end of a pass: the cycle after bank 7's second period, where the done pulse, the return to idle or an immediate restart, and the bank wrap all happen on one edge. The bench reaches it by running whole passes to completion under several timing sets, and once with start held high so that the restart lands on the done cycle. Filler truncation is the other corner that is hard to reach. It is covered by the tightest legal set (1, 2, 3), which leaves no filler at all, and by sets whose gaps are not multiples of four.

// File: rtl/cmd_loop_pkg.sv
package cmd_loop_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_PRE  = 3'd3,
    CMD_DES  = 3'd4,
    CMD_NOP  = 3'd5
  } cmd_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic active;   // pass in progress, outputs live
    logic loadCfg;  // capture timing counts
    logic clrCnt;   // restart position at bank 0, cycle 0
    logic advance;  // step position by one cycle
  } seqStrobe_t;

endpackage

// File: rtl/cmd_loop_ctrl.sv
module cmd_loop_ctrl
  import cmd_loop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cfgOk,
  input  logic       loopEnd,
  output seqStrobe_t strb,
  output logic       loopDone,
  output logic       cfgErr
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e stateQ;
  logic   launch;

  // A pass may begin from idle, or back-to-back at the end of a pass
  always_comb begin
    launch = 1'b0;
    if (start && cfgOk) begin
      if (stateQ == ST_IDLE) launch = 1'b1;
      else if (loopEnd)      launch = 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.active  = (stateQ == ST_RUN);
    strb.advance = (stateQ == ST_RUN);
    strb.loadCfg = launch;
    strb.clrCnt  = launch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      loopDone <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      loopDone <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            if (cfgOk) begin
              stateQ <= ST_RUN;
              cfgErr <= 1'b0;
            end else begin
              cfgErr <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (loopEnd) begin
            loopDone <= 1'b1;
            if (launch) begin
              stateQ <= ST_RUN;
              cfgErr <= 1'b0;
            end else begin
              stateQ <= ST_IDLE;
              if (start) cfgErr <= 1'b1;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_loop_dp.sv
module cmd_loop_dp
  import cmd_loop_pkg::*;
#(
  parameter int          CNT_W      = 8,
  parameter int          NUM_BANKS  = 8,
  parameter int          BANK_W     = 3,
  parameter int          FILL_LEN   = 4,
  parameter logic [7:0]  PAT_FIRST  = 8'h00,
  parameter logic [7:0]  PAT_SECOND = 8'h33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strb,
  input  logic [CNT_W-1:0]  rcdIn,
  input  logic [CNT_W-1:0]  rasIn,
  input  logic [CNT_W-1:0]  rcIn,
  output logic              cfgOk,
  output logic              loopEnd,
  output logic [2:0]        cmdCode,
  output logic [BANK_W-1:0] bankAddr,
  output logic [7:0]        dataPat,
  output logic              dmLevel
);

  localparam int                FILL_W    = (FILL_LEN > 1) ? $clog2(FILL_LEN) : 1;
  localparam logic [FILL_W-1:0] FILL_DES  = FILL_W'(FILL_LEN / 2);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(FILL_LEN - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [CNT_W-1:0]  rcdQ, rasQ, rcQ;
  logic [CNT_W-1:0]  cycQ;
  logic              halfQ;
  logic [BANK_W-1:0] bankQ;
  logic [FILL_W-1:0] fillQ;

  logic isAct, isRd, isPre, slotIsCmd, periodEnd;
  cmd_e cmdNext;

  // Legality of the live inputs: 0 < nRCD < nRAS < nRC
  assign cfgOk = (rcdIn != '0) && (rcdIn < rasIn) && (rasIn < rcIn);

  assign isAct     = (cycQ == '0);
  assign isRd      = (cycQ == rcdQ);
  assign isPre     = (cycQ == rasQ);
  assign slotIsCmd = isAct || isRd || isPre;
  assign periodEnd = (cycQ == rcQ - CNT_W'(1));
  assign loopEnd   = strb.active && periodEnd && halfQ && (bankQ == LAST_BANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcdQ  <= '0;
      rasQ  <= '0;
      rcQ   <= '0;
      cycQ  <= '0;
      halfQ <= 1'b0;
      bankQ <= '0;
      fillQ <= '0;
    end else begin
      if (strb.loadCfg) begin
        rcdQ <= rcdIn;
        rasQ <= rasIn;
        rcQ  <= rcIn;
      end
      if (strb.clrCnt) begin
        cycQ  <= '0;
        halfQ <= 1'b0;
        bankQ <= '0;
        fillQ <= '0;
      end else if (strb.advance) begin
        if (periodEnd) begin
          cycQ  <= '0;
          halfQ <= ~halfQ;
          if (halfQ) bankQ <= (bankQ == LAST_BANK) ? '0 : bankQ + BANK_W'(1);
        end else begin
          cycQ <= cycQ + CNT_W'(1);
        end
        // filler phase restarts after each command, wraps at FILL_LEN
        if (slotIsCmd)               fillQ <= '0;
        else if (fillQ == FILL_LAST) fillQ <= '0;
        else                         fillQ <= fillQ + FILL_W'(1);
      end
    end
  end

  always_comb begin
    if (!strb.active)          cmdNext = CMD_IDLE;
    else if (isAct)            cmdNext = CMD_ACT;
    else if (isRd)             cmdNext = CMD_RD;
    else if (isPre)            cmdNext = CMD_PRE;
    else if (fillQ < FILL_DES) cmdNext = CMD_DES;
    else                       cmdNext = CMD_NOP;
  end

  assign cmdCode  = cmdNext;
  assign bankAddr = strb.active ? bankQ : '0;
  assign dataPat  = (cmdNext == CMD_RD) ? (halfQ ? PAT_SECOND : PAT_FIRST) : 8'h00;
  assign dmLevel  = 1'b0;

endmodule

// File: rtl/cmd_loop_seq.sv
module cmd_loop_seq
  import cmd_loop_pkg::*;
#(
  parameter int         CNT_W      = 8,
  parameter int         NUM_BANKS  = 8,
  parameter int         FILL_LEN   = 4,
  parameter logic [7:0] PAT_FIRST  = 8'h00,
  parameter logic [7:0] PAT_SECOND = 8'h33,
  localparam int        BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  rcdCycles,
  input  logic [CNT_W-1:0]  rasCycles,
  input  logic [CNT_W-1:0]  rcCycles,
  output logic [2:0]        cmdCode,
  output logic [BANK_W-1:0] bankAddr,
  output logic [7:0]        dataPat,
  output logic              dmLevel,
  output logic              loopDone,
  output logic              cfgErr
);

  seqStrobe_t strb;
  logic       cfgOk;
  logic       loopEnd;

  cmd_loop_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfgOk    (cfgOk),
    .loopEnd  (loopEnd),
    .strb     (strb),
    .loopDone (loopDone),
    .cfgErr   (cfgErr)
  );

  cmd_loop_dp #(
    .CNT_W      (CNT_W),
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .FILL_LEN   (FILL_LEN),
    .PAT_FIRST  (PAT_FIRST),
    .PAT_SECOND (PAT_SECOND)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .rcdIn    (rcdCycles),
    .rasIn    (rasCycles),
    .rcIn     (rcCycles),
    .cfgOk    (cfgOk),
    .loopEnd  (loopEnd),
    .cmdCode  (cmdCode),
    .bankAddr (bankAddr),
    .dataPat  (dataPat),
    .dmLevel  (dmLevel)
  );

endmodule

// File: rtl/cmd_loop_seq_chk.sv
module cmd_loop_seq_chk
  import cmd_loop_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmdCode,
  input logic [BANK_W-1:0] bankAddr,
  input logic [7:0]        dataPat,
  input logic              dmLevel,
  input logic              loopDone,
  input logic              cfgErr
);

  // R1: nRC is at least 3, so two activates never sit side by side
  a_r1_no_double_act: assert property (@(posedge clk) disable iff (!rst_n)
    cmdCode == CMD_ACT |=> cmdCode != CMD_ACT);

  // R3: the slot after a precharge is filler phase 0, a new period, or idle
  a_r3_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    cmdCode == CMD_PRE |=> (cmdCode == CMD_DES || cmdCode == CMD_ACT || cmdCode == CMD_IDLE));

  // R4: the bank address only moves on an activate within a pass
  a_r4_bank_on_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode != CMD_IDLE && $past(cmdCode) != CMD_IDLE && bankAddr != $past(bankAddr))
      |-> cmdCode == CMD_ACT);

  // R5: a non-zero data pattern only accompanies a read
  a_r5_pat_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dataPat != 8'h00 |-> cmdCode == CMD_RD);

  // R6: mask held low
  a_r6_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    dmLevel == 1'b0);

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    loopDone |=> !loopDone);

  // R10: an error flag means no command stream
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |-> cmdCode == CMD_IDLE);

endmodule

bind cmd_loop_seq cmd_loop_seq_chk #(.BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmdCode  (cmdCode),
  .bankAddr (bankAddr),
  .dataPat  (dataPat),
  .dmLevel  (dmLevel),
  .loopDone (loopDone),
  .cfgErr   (cfgErr)
);

// File: tb/cmd_loop_seq_tb.sv
module cmd_loop_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] rcd = 8'd0, ras = 8'd0, rc = 8'd0;
  logic [2:0] cmdCode;
  logic [2:0] bankAddr;
  logic [7:0] dataPat;
  logic       dmLevel, loopDone, cfgErr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cmd_loop_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rcdCycles (rcd),
    .rasCycles (ras),
    .rcCycles  (rc),
    .cmdCode   (cmdCode),
    .bankAddr  (bankAddr),
    .dataPat   (dataPat),
    .dmLevel   (dmLevel),
    .loopDone  (loopDone),
    .cfgErr    (cfgErr)
  );

  // {nRCD, nRAS, nRC, expected pass length}
  localparam logic [39:0] VECS [5] = '{
    {8'd1, 8'd2,  8'd3,  16'd48},
    {8'd2, 8'd5,  8'd9,  16'd144},
    {8'd4, 8'd10, 8'd13, 16'd208},
    {8'd5, 8'd6,  8'd7,  16'd112},
    {8'd3, 8'd9,  8'd20, 16'd320}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expCmd(input int c, input int rcdV, input int rasV);
    int last;
    int p;
    if (c == 0)    return 1;
    if (c == rcdV) return 2;
    if (c == rasV) return 3;
    last = (c > rasV) ? rasV : ((c > rcdV) ? rcdV : 0);
    p = (c - last - 1) % 4;
    return (p < 2) ? 4 : 5;
  endfunction

  task automatic doReset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(cmdCode == 3'd0, "R11 cmd in reset", cmdCode, 0);
    check(bankAddr == 3'd0 && loopDone == 1'b0 && cfgErr == 1'b0,
          "R11 bank/done/err in reset", {bankAddr, loopDone, cfgErr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic runPass(input int rcdV, input int rasV, input int rcV, input int lenV, input bit hold);
    int c, h, b, ec, ep;
    string tag;
    rcd = 8'(rcdV); ras = 8'(rasV); rc = 8'(rcV);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    // R9: new (legal) counts during the pass must not disturb it
    rcd = 8'd2; ras = 8'd3; rc = 8'd4;
    for (int k = 0; k < lenV; k++) begin
      if (k > 0) @(negedge clk);
      c = k % rcV;
      h = (k / rcV) % 2;
      b = k / (2 * rcV);
      ec = expCmd(c, rcdV, rasV);
      if (c == 0) tag = (k == 0) ? "R7 first activate" : "R1 activate at period start";
      else if (ec == 2 || ec == 3) tag = "R2 read/precharge position (R9 latched)";
      else tag = "R3 filler slot";
      check(cmdCode == 3'(ec), tag, cmdCode, ec);
      check(bankAddr == 3'(b), "R4 bank of sub-loop", bankAddr, b);
      ep = (ec == 2) ? (h ? 8'h33 : 8'h00) : 8'h00;
      check(dataPat == 8'(ep), "R5 data pattern", dataPat, ep);
      check(dmLevel == 1'b0, "R6 mask level", dmLevel, 0);
      check(loopDone == 1'b0, "R8 no done inside pass", loopDone, 0);
    end
    @(negedge clk);
    check(loopDone == 1'b1, "R8 done after last cycle", loopDone, 1);
    if (hold) begin
      check(cmdCode == 3'd1, "R8 restart activate", cmdCode, 1);
      check(bankAddr == 3'd0, "R8 restart bank 0", bankAddr, 0);
    end else begin
      check(cmdCode == 3'd0, "R8 idle after pass", cmdCode, 0);
      @(negedge clk);
      check(loopDone == 1'b0, "R8 done single cycle", loopDone, 0);
      check(cmdCode == 3'd0, "R8 stays idle", cmdCode, 0);
    end
  endtask

  task automatic badStart(input int rcdV, input int rasV, input int rcV);
    rcd = 8'(rcdV); ras = 8'(rasV); rc = 8'(rcV);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfgErr == 1'b1, "R10 error flag", cfgErr, 1);
    for (int i = 0; i < 3; i++) begin
      check(cmdCode == 3'd0, "R10 stays idle", cmdCode, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    doReset();

    // table of timing sets, one full pass each
    for (int v = 0; v < 5; v++) begin
      runPass(int'(VECS[v][39:32]), int'(VECS[v][31:24]), int'(VECS[v][23:16]),
              int'(VECS[v][15:0]), 1'b0);
    end

    // R8: start held across the end of a pass restarts it at once
    runPass(1, 2, 3, 48, 1'b1);
    start = 1'b0;
    // R11: reset in the middle of a pass
    @(negedge clk);
    doReset();

    // R9: counts changed right after start are ignored
    rcd = 8'd2; ras = 8'd4; rc = 8'd6;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rcd = 8'd1; ras = 8'd2; rc = 8'd3;
    check(cmdCode == 3'd1, "R9 activate", cmdCode, 1);
    @(negedge clk);
    check(cmdCode == 3'd4, "R9 latched counts, filler", cmdCode, 4);
    @(negedge clk);
    check(cmdCode == 3'd2, "R9 latched counts, read", cmdCode, 2);
    @(negedge clk);
    check(cmdCode == 3'd4, "R9 latched counts, filler", cmdCode, 4);
    @(negedge clk);
    check(cmdCode == 3'd3, "R9 latched counts, precharge", cmdCode, 3);
    doReset();

    // R10: illegal orderings
    badStart(2, 2, 5);
    badStart(3, 2, 5);
    badStart(0, 1, 3);
    badStart(1, 4, 4);
    rcd = 8'd1; ras = 8'd2; rc = 8'd3;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfgErr == 1'b0, "R10 error cleared", cfgErr, 0);
    check(cmdCode == 3'd1, "R10 legal start runs", cmdCode, 1);
    doReset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule